// File: doc/BRIEF.md
# LLR Window Syndrome Screener

This block decides quickly whether a window of soft channel samples, taken at some candidate alignment of a continuous stream, looks like a codeword of a fixed sparse parity-check code. Each arriving log-likelihood ratio is turned into a hard bit from its sign. Every parity check of the code is updated with that bit as the sample arrives. Once the whole window has been seen, the block reports how many checks fail.

A frame-alignment search feeds it one candidate window at a time. A correctly aligned window gives a weight at or near zero. A misaligned window gives a weight near half the number of checks. The block compares the weight with a run-time threshold and raises a pass flag for candidates worth a full decode. It also gives an exact zero-syndrome flag. Samples arrive over a valid/ready stream, and a start strobe marks the first sample of each window.

Top module: `syn_screen_top`

## Requirements
- R1: A sample whose LLR (6-bit two's complement) is negative gives hard bit 1. A sample that is zero or positive gives hard bit 0.
- R2: A window is 256 samples. Sample k of the window is code bit k. There are 224 checks. Check r covers code bits (5*r + 64*d) mod 256 for d = 0..3. The weight never exceeds 224.
- R3: `weight` is the number of checks whose XOR over their covered hard bits is 1. The block registers it on the clock edge that accepts sample 255. `done` is high for exactly the one cycle that follows that edge.
- R4: `zero_syn` is 1 after a window exactly when that window's weight is 0.
- R5: `pass` is 1 after a window exactly when weight < threshold. The threshold register resets to 50 and is loaded from `thr_wdata` when `thr_we` is high. A load on the same edge as sample 255 affects only later windows.
- R6: A sample accepted with `in_start` high is sample 0 of a new window. This also holds in the middle of an open window, where the partial window is discarded.
- R7: Samples with `in_valid` low have no effect, whatever `in_start` and `in_llr` carry. Accepted samples with `in_start` low while no window is open also have no effect.
- R8: After reset, `weight`, `zero_syn`, `pass` and `done` are all 0. Between windows, `weight`, `zero_syn` and `pass` hold their last values.
- R9: `in_ready` is 1 from the first cycle after reset. The stream is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample accepted when high with in_valid |
| in_start | input | 1 | Marks sample 0 of a window |
| in_llr | input | 6 | Signed LLR sample |
| thr_we | input | 1 | Load threshold register |
| thr_wdata | input | 9 | New threshold value |
| weight | output | 9 | Syndrome weight of last window |
| zero_syn | output | 1 | Last window had weight 0 |
| pass | output | 1 | Last window weight below threshold |
| done | output | 1 | One-cycle pulse: new result on outputs |

## Verification
Two events can fall in the same cycle: a threshold load and the final sample of a window. Both touch the pass decision. The bench writes threshold 0 on the very edge that accepts sample 255 of an all-zero window. The correct outcome is pass still 1, because the old threshold of 50 applies. The next all-zero window must then give pass 0 under the new threshold. A restart strobe arriving inside an open window is also provoked. There the result must match only the samples that follow the restart.

// File: rtl/syn_pkg.sv
package syn_pkg;
  localparam int DEF_BITS   = 256;
  localparam int DEF_CHECKS = 224;
  localparam int DEF_DEG    = 4;
  localparam int DEF_STEP   = 5;
  localparam int DEF_LLR_W  = 6;
  localparam int DEF_WT_W   = 9;
  localparam int DEF_THR    = 50;

  // code bit covered by tap d of check row
  function automatic int col_of(input int row, input int d, input int n_bits,
                                input int deg, input int step);
    return (row * step + d * (n_bits / deg)) % n_bits;
  endfunction
endpackage

// File: rtl/syn_window_ctrl.sv
module syn_window_ctrl #(
  parameter int N_BITS = 256,
  parameter int IDX_W  = $clog2(N_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_start,
  output logic             ready,
  output logic             acc,
  output logic             first,
  output logic             last,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BITS - 1);

  logic             ready_q;
  logic             open_q;
  logic [IDX_W-1:0] idx_q;

  assign ready = ready_q;
  assign acc   = in_valid & ready_q & (in_start | open_q);
  assign first = acc & in_start;
  assign idx   = in_start ? '0 : idx_q;
  assign last  = acc & (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      open_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      if (acc) begin
        idx_q  <= idx + 1'b1;
        open_q <= ~last;
      end
    end
  end
endmodule

// File: rtl/syn_parity_bank.sv
module syn_parity_bank #(
  parameter int N_BITS   = 256,
  parameter int N_CHECKS = 224,
  parameter int DEG      = 4,
  parameter int STEP     = 5,
  parameter int IDX_W    = $clog2(N_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc,
  input  logic                first,
  input  logic                bit_in,
  input  logic [IDX_W-1:0]    idx,
  output logic [N_CHECKS-1:0] par_next
);
  logic [N_CHECKS-1:0] par_q;

  for (genvar r = 0; r < N_CHECKS; r++) begin : g_row
    logic [DEG-1:0] hit;
    for (genvar d = 0; d < DEG; d++) begin : g_tap
      localparam int COL = syn_pkg::col_of(r, d, N_BITS, DEG, STEP);
      assign hit[d] = (idx == IDX_W'(COL));
    end
    assign par_next[r] = acc ? ((first ? 1'b0 : par_q[r]) ^ (bit_in & (|hit)))
                             : par_q[r];
  end

  always_ff @(posedge clk) begin
    if (rst) par_q <= '0;
    else     par_q <= par_next;
  end
endmodule

// File: rtl/syn_popcount.sv
module syn_popcount #(
  parameter int W     = 224,
  parameter int OUT_W = 9
) (
  input  logic [W-1:0]     bits,
  output logic [OUT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) count = count + OUT_W'(bits[i]);
  end
endmodule

// File: rtl/syn_screen_top.sv
module syn_screen_top #(
  parameter int N_BITS   = syn_pkg::DEF_BITS,
  parameter int N_CHECKS = syn_pkg::DEF_CHECKS,
  parameter int DEG      = syn_pkg::DEF_DEG,
  parameter int STEP     = syn_pkg::DEF_STEP,
  parameter int LLR_W    = syn_pkg::DEF_LLR_W,
  parameter int WT_W     = syn_pkg::DEF_WT_W,
  parameter int THR_RST  = syn_pkg::DEF_THR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_start,
  input  logic [LLR_W-1:0] in_llr,
  input  logic             thr_we,
  input  logic [WT_W-1:0]  thr_wdata,
  output logic [WT_W-1:0]  weight,
  output logic             zero_syn,
  output logic             pass,
  output logic             done
);
  localparam int IDX_W = $clog2(N_BITS);

  logic                acc, first, last;
  logic [IDX_W-1:0]    idx;
  logic [N_CHECKS-1:0] par_next;
  logic [WT_W-1:0]     cnt;
  logic [WT_W-1:0]     thr_q;
  logic                hard_bit;

  // sign bit is the hard decision: negative -> 1, zero/positive -> 0
  assign hard_bit = in_llr[LLR_W-1];

  syn_window_ctrl #(.N_BITS(N_BITS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .ready(in_ready), .acc(acc), .first(first), .last(last), .idx(idx)
  );

  syn_parity_bank #(.N_BITS(N_BITS), .N_CHECKS(N_CHECKS), .DEG(DEG),
                    .STEP(STEP), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .acc(acc), .first(first), .bit_in(hard_bit),
    .idx(idx), .par_next(par_next)
  );

  syn_popcount #(.W(N_CHECKS), .OUT_W(WT_W)) u_pop (
    .bits(par_next), .count(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= WT_W'(THR_RST);
    end else if (thr_we) begin
      thr_q <= thr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      weight   <= '0;
      zero_syn <= 1'b0;
      pass     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= last;
      if (last) begin
        weight   <= cnt;
        zero_syn <= (cnt == '0);
        pass     <= (cnt < thr_q);
      end
    end
  end
endmodule

// File: rtl/syn_screen_chk.sv
module syn_screen_chk #(
  parameter int N_CHECKS = 224,
  parameter int WT_W     = 9
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [WT_W-1:0] weight,
  input logic            zero_syn,
  input logic            pass,
  input logic            done,
  input logic [WT_W-1:0] thr_q
);
  AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(in_valid && in_ready));  // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R3
  AST_WT_RANGE: assert property (@(posedge clk) disable iff (rst)
    weight <= WT_W'(N_CHECKS));  // R2
  AST_ZERO_WT: assert property (@(posedge clk) disable iff (rst)
    zero_syn |-> (weight == '0));  // R4
  AST_ZERO_SET: assert property (@(posedge clk) disable iff (rst)
    (done && weight == '0) |-> zero_syn);  // R4
  AST_PASS_THR: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass == (weight < $past(thr_q))));  // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(weight) && $stable(pass) && $stable(zero_syn)));  // R8
  AST_READY: assert property (@(posedge clk) disable iff (rst)
    !rst |=> in_ready);  // R9
endmodule

bind syn_screen_top syn_screen_chk #(.N_CHECKS(N_CHECKS), .WT_W(WT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .weight(weight), .zero_syn(zero_syn), .pass(pass), .done(done),
  .thr_q(thr_q)
);

// File: tb/test_syn_screen_top.sv
module test_syn_screen_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_ready, in_start;
  logic [5:0] in_llr;
  logic       thr_we;
  logic [8:0] thr_wdata;
  logic [8:0] weight;
  logic       zero_syn, pass, done;

  int n_run  = 0;
  int n_fail = 0;
  bit thr_last_en = 1'b0;
  logic [8:0] thr_last_val = '0;

  always #2.5 clk = ~clk;

  syn_screen_top i_syn_screen_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_llr(in_llr), .thr_we(thr_we),
    .thr_wdata(thr_wdata), .weight(weight), .zero_syn(zero_syn),
    .pass(pass), .done(done)
  );

  function automatic int col_b(int r, int d);
    return (r * 5 + d * 64) % 256;
  endfunction

  function automatic int model_wt(bit [255:0] w);
    int wt = 0;
    for (int r = 0; r < 224; r++) begin
      bit p = 1'b0;
      for (int d = 0; d < 4; d++) p ^= w[col_b(r, d)];
      wt += int'(p);
    end
    return wt;
  endfunction

  // bit 1 -> -1..-32, bit 0 -> 0..31 (zero included)
  function automatic logic [5:0] llr_for(bit b, int i);
    if (b) return 6'(-(1 + (i * 7) % 32));
    else   return 6'((i * 3) % 32);
  endfunction

  function automatic bit [255:0] rand_win();
    bit [255:0] w;
    for (int k = 0; k < 8; k++) w[k*32 +: 32] = $urandom;
    return w;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_samples(bit [255:0] w, int count, bit gaps);
    for (int i = 0; i < count; i++) begin
      if (gaps && i > 0 && i % 3 == 0) begin
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b1; in_llr = 6'h3f;  // R7: ignored
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_start = (i == 0);
      in_llr   = llr_for(w[i], i);
      if (i == 255 && thr_last_en) begin
        thr_we = 1'b1; thr_wdata = thr_last_val;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; thr_we = 1'b0;
  endtask

  // called at negedge right after the window's last accepted sample
  task automatic expect_result(string req, int wt, int thr);
    check({req, " done"}, int'(done), 1);
    check({req, " weight"}, int'(weight), wt);
    check({req, " zero_syn R4"}, int'(zero_syn), int'(wt == 0));
    check({req, " pass R5"}, int'(pass), int'(wt < thr));
    @(negedge clk);
    check({req, " done drops R3"}, int'(done), 0);
    check({req, " weight holds R8"}, int'(weight), wt);
  endtask

  task automatic write_thr(logic [8:0] v);
    @(negedge clk);
    thr_we = 1'b1; thr_wdata = v;
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; in_start = 1'b0; in_llr = '0;
    thr_we = 1'b0; thr_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset weight", int'(weight), 0);
    check("R8 reset zero_syn", int'(zero_syn), 0);
    check("R8 reset pass", int'(pass), 0);
    check("R8 reset done", int'(done), 0);
    check("R9 ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_all_zero();
    send_samples('0, 256, 1'b0);
    expect_result("R1 zero/positive LLR window", 0, 50);
  endtask

  task automatic t_single_bit();
    bit [255:0] w = '0;
    w[9] = 1'b1;  // LLR -32 at this column
    send_samples(w, 256, 1'b0);
    expect_result("R1 single negative", model_wt(w), 50);
    w = '0; w[255] = 1'b1;
    send_samples(w, 256, 1'b0);
    expect_result("R2 last column", model_wt(w), 50);
  endtask

  task automatic t_random();
    for (int k = 0; k < 3; k++) begin
      bit [255:0] w = rand_win();
      send_samples(w, 256, 1'b0);
      expect_result("R3 random window", model_wt(w), 50);
    end
  endtask

  task automatic t_threshold();
    bit [255:0] w = rand_win();
    write_thr(9'd300);
    send_samples(w, 256, 1'b0);
    expect_result("R5 large threshold", model_wt(w), 300);
    write_thr(9'd50);
    // threshold load on the edge of the last sample: old value applies
    thr_last_en = 1'b1; thr_last_val = 9'd0;
    send_samples('0, 256, 1'b0);
    thr_last_en = 1'b0;
    expect_result("R5 same-cycle load uses old", 0, 50);
    send_samples('0, 256, 1'b0);
    expect_result("R5 new threshold zero", 0, 0);
    write_thr(9'd50);
  endtask

  task automatic t_restart();
    bit [255:0] a = rand_win();
    bit [255:0] b = rand_win();
    send_samples(a, 100, 1'b0);
    check("R6 no done on partial", int'(done), 0);
    send_samples(b, 256, 1'b0);
    expect_result("R6 mid-window restart", model_wt(b), 50);
  endtask

  task automatic t_stray_and_gaps();
    bit [255:0] w = rand_win();
    int prev = int'(weight);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; in_start = 1'b0; in_llr = 6'h3b;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check("R7 stray no done", int'(done), 0);
    check("R7 stray weight held", int'(weight), prev);
    send_samples(w, 256, 1'b1);
    expect_result("R7 gapped window", model_wt(w), 50);
  endtask

  initial begin
    t_reset();
    t_all_zero();
    t_single_bit();
    t_random();
    t_threshold();
    t_restart();
    t_stray_and_gaps();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule